// File: doc/BRIEF.md
# Serial-Bus Eight-Line I/O Expander Controller

This block is the bus-facing controller of an eight-line open-drain I/O expander. It listens to a two-wire serial bus as a slave with a 7-bit address. It recognises START and STOP conditions and clocks in the address byte with its direction bit. When the address matches, it pulls SDA low during the ninth clock to acknowledge. A write loads each data byte that follows into the eight port output latches. A read returns port levels and change flags in alternation, for as long as the master keeps acknowledging.

SDA and SCL reach the block as samples that are already synchronised to `clk`. SDA leaves the block as an open-drain pull-down enable. A companion transition detector keeps the change flags. It receives a single-cycle sample strobe and a single-cycle clear strobe from this controller. A separate active-low abort input ends any transfer in progress. It does not touch the port latches or the companion's interrupt state.

The data paths here are bit-serial and paced only by SCL, so there is no valid/ready stream to expose. Port latches, strobes and flags are plain level or pulse signals.

Top module: `pexp_ctrl`

## Requirements
- R1: After `rst_n` is released, `port_out` equals the `RESET_PORTS` parameter (default 8'hFF), `sda_oe` is 0, and `sample_stb` and `clear_stb` are 0.
- R2: The slave address is {1,1,0, `addr_sel[3:0]`}, covering 0x60 to 0x6F. It is sent MSB first, followed by the direction bit (0 = write, 1 = read). On a match, `sda_oe` goes high only while SCL is low and stays high through the ninth (ACK) clock.
- R3: In a write, each data byte after the address is acknowledged and replaces all eight bits of `port_out`. A write may carry any number of data bytes before STOP, and `port_out` changes only while SCL is low.
- R4: An address byte that does not match gets no acknowledge. `sda_oe` stays 0 from then until the next START, and later bytes change nothing.
- R5: In a read, bytes 1, 3, 5 and so on carry `pin_lvl`, MSB first. The value is the one captured at the ACK clock just before that byte: the address ACK for byte 1, and the master's ACK for the later port bytes.
- R6: In a read, bytes 2, 4 and so on carry the `chg_flags` value captured at the same ACK as the port byte that came just before.
- R7: `sample_stb` and `clear_stb` give one-cycle pulses together while SCL is high. They pulse at the address ACK and at each master ACK that is followed by a port byte, and never at an ACK that is followed by a flag byte.
- R8: A `port_out` bit of 1 means the line is released. A read returns the real line level `pin_lvl`, not the latch value.
- R9: When the master does not acknowledge a read byte, the controller releases SDA, gives no strobe, and ignores the bus until the next START.
- R10: While `abort_n` is low, the controller goes back to idle and releases SDA on the next clock. `port_out` and the strobes are not affected, and the bus is ignored until a new START.
- R11: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START with no STOP before it begins address reception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset for the whole block |
| abort_n | input | 1 | Active-low bus abort: returns the controller to idle only |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (the wired line) |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_sel | input | 4 | Low four address bits from the address-select decoder |
| pin_lvl | input | 8 | Actual levels on the eight port lines |
| chg_flags | input | 8 | Change flags held by the companion detector |
| port_out | output | 8 | Port output latches (1 = released) |
| sample_stb | output | 1 | Pulse: the companion takes a new snapshot |
| clear_stb | output | 1 | Pulse: the companion clears its flags |

## Verification
On every cycle, the assertions check that the strobes are single-cycle pulses issued with SCL high. They also check that SDA is only taken while SCL is low, that the latches change only while SCL is low, and that an abort releases SDA and freezes the latches. Some behaviour can only be shown by the bench's bus scenarios: that byte contents alternate between pins and flags, that resampling happens only before port bytes, that a NACK suppresses the strobe, that a mismatched or aborted transfer stays silent, and that a repeated START restarts addressing. For these, the bench's reference model tracks the expected latch value and whether the slave may drive SDA, and compares both on every clock.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_MACK
  } bus_st_t;
endpackage

// File: rtl/pexp_bus_cond.sv
module pexp_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  // SCL edges between two consecutive samples
  assign scl_rise = scl_i & ~scl_p;
  assign scl_fall = ~scl_i & scl_p;
  // SDA moving while SCL holds high
  assign start_c  = scl_i & scl_p & sda_p & ~sda_i;
  assign stop_c   = scl_i & scl_p & ~sda_p & sda_i;
endmodule

// File: rtl/pexp_port_regs.sv
module pexp_port_regs #(
  parameter int          NPORT       = 8,
  parameter logic [7:0]  RESET_PORTS = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPORT-1:0] wr_data,
  input  logic             cap_en,
  input  logic [NPORT-1:0] pin_lvl,
  input  logic [NPORT-1:0] chg_flags,
  output logic [NPORT-1:0] port_out,
  output logic [NPORT-1:0] snap,
  output logic [NPORT-1:0] flag_cap
);
  for (genvar g = 0; g < NPORT; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        port_out[g] <= RESET_PORTS[g];
        snap[g]     <= 1'b0;
        flag_cap[g] <= 1'b0;
      end else begin
        if (wr_en)
          port_out[g] <= wr_data[g];
        if (cap_en) begin
          snap[g]     <= pin_lvl[g];
          flag_cap[g] <= chg_flags[g];
        end
      end
    end
  end
endmodule

// File: rtl/pexp_ctrl.sv
module pexp_ctrl #(
  parameter int         NPORT       = pexp_pkg::BYTE_W,
  parameter int         SEL_W       = 4,
  parameter int         HI_W        = 3,
  parameter logic [2:0] ADDR_HI     = 3'b110,
  parameter logic [7:0] RESET_PORTS = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [SEL_W-1:0] addr_sel,
  input  logic [NPORT-1:0] pin_lvl,
  input  logic [NPORT-1:0] chg_flags,
  output logic [NPORT-1:0] port_out,
  output logic             sample_stb,
  output logic             clear_stb
);
  import pexp_pkg::*;

  localparam int ADDR_W = HI_W + SEL_W;
  localparam int CNT_W  = $clog2(NPORT + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(NPORT);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(NPORT - 1);

  logic scl_rise, scl_fall, start_c, stop_c;
  bus_st_t st;
  logic [CNT_W-1:0] cnt;
  logic [NPORT-1:0] shreg, txsh, snap, flag_cap, next_tx;
  logic rw, nxt_port, m_ack, stb_q;
  logic [ADDR_W-1:0] my_addr;
  logic bus_ok, cap_now, wr_en;

  pexp_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  assign my_addr = {ADDR_HI[HI_W-1:0], addr_sel};
  assign bus_ok  = abort_n & ~start_c & ~stop_c;

  // snapshot point: address ACK, or master ACK ahead of a port byte
  assign cap_now = bus_ok & scl_rise &
                   ((st == ST_ACK_A) | ((st == ST_MACK) & ~sda_i & nxt_port));
  assign wr_en   = bus_ok & scl_fall & (st == ST_WR) & (cnt == LAST_RX);
  assign next_tx = nxt_port ? snap : flag_cap;

  pexp_port_regs #(.NPORT(NPORT), .RESET_PORTS(RESET_PORTS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(shreg),
    .cap_en(cap_now), .pin_lvl(pin_lvl), .chg_flags(chg_flags),
    .port_out(port_out), .snap(snap), .flag_cap(flag_cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txsh     <= '0;
      rw       <= 1'b0;
      nxt_port <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= cap_now;
      if (!abort_n) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[NPORT-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_RX) begin
              if (shreg[NPORT-1:1] == my_addr) begin
                st     <= ST_ACK_A;
                sda_oe <= 1'b1;
                rw     <= shreg[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st       <= ST_RD;
                txsh     <= snap;
                sda_oe   <= ~snap[NPORT-1];
                nxt_port <= 1'b0;
              end else begin
                st     <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[NPORT-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_RX) begin
              st     <= ST_ACK_W;
              sda_oe <= 1'b1;
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              st     <= ST_WR;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_TX) begin
                st     <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                txsh   <= {txsh[NPORT-2:0], 1'b0};
                sda_oe <= ~txsh[NPORT-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_i;
            end else if (scl_fall) begin
              if (m_ack) begin
                st       <= ST_RD;
                cnt      <= '0;
                txsh     <= next_tx;
                sda_oe   <= ~next_tx[NPORT-1];
                nxt_port <= ~nxt_port;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sample_stb = stb_q;
  assign clear_stb  = stb_q;
endmodule

// File: rtl/pexp_ctrl_chk.sv
module pexp_ctrl_chk #(
  parameter int NPORT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             abort_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [NPORT-1:0] port_out,
  input logic             sample_stb,
  input logic             clear_stb
);
  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_n |=> !sda_oe);

  // R10
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_n |=> $stable(port_out));

  // R3
  port_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> !scl_i);

  // R7
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R7
  stb_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || clear_stb) |-> scl_i);

  // R2
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind pexp_ctrl pexp_ctrl_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .scl_i(scl_i),
  .sda_oe(sda_oe), .port_out(port_out),
  .sample_stb(sample_stb), .clear_stb(clear_stb)
);

// File: tb/pexp_ctrl_tb.sv
module pexp_ctrl_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, abort_n, scl_m, sda_m;
  logic [3:0] addr_sel;
  logic [7:0] ext_hi, chg_val, chg_reg;
  logic chg_load;
  wire  sda_oe;
  wire  [7:0] port_out;
  wire  sample_stb, clear_stb;
  wire  sda_line = sda_m & ~sda_oe;
  wire  [7:0] pin_lvl = port_out & ext_hi;

  pexp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .abort_n(abort_n),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .pin_lvl(pin_lvl), .chg_flags(chg_reg),
    .port_out(port_out), .sample_stb(sample_stb), .clear_stb(clear_stb)
  );

  // companion flag holder: cleared by the strobe, loaded by the bench
  always @(posedge clk) begin
    if (clear_stb) chg_reg <= 8'h00;
    else if (chg_load) chg_reg <= chg_val;
  end

  integer n_chk = 0, n_bad = 0, smp_cnt = 0;
  logic started = 1'b0, done = 1'b0;
  // reference model
  logic [7:0] exp_port = 8'hFF;
  logic wr_win = 1'b0, quiet = 1'b1;

  always @(posedge clk) if (rst_n && sample_stb) smp_cnt <= smp_cnt + 1;

  always @(negedge clk) begin
    if (started && !done) begin
      n_chk = n_chk + 1;
      if (!wr_win && port_out !== exp_port) begin
        n_bad = n_bad + 1;
        $display("FAIL R3 latch: got %0h expected %0h", port_out, exp_port);
      end
      if (quiet && sda_oe !== 1'b0) begin
        n_bad = n_bad + 1;
        $display("FAIL R4/R9/R10 drive: got %0b expected 0", sda_oe);
      end
    end
  end

  task automatic check(input logic ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4); scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(4);
    sda_m = 1'b1; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(2); sda_m = b[i]; tick(4);
      scl_m = 1'b1; tick(8); scl_m = 1'b0;
    end
    tick(2); sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4); ack = ~sda_line; tick(4); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(6); scl_m = 1'b1; tick(4); b[i] = sda_line; tick(4); scl_m = 1'b0;
    end
    tick(2); sda_m = ~mack; tick(4);
    scl_m = 1'b1; tick(8); scl_m = 1'b0; tick(2); sda_m = 1'b1;
  endtask

  task automatic write_data(input logic [7:0] b, input string tag);
    logic a;
    wr_win = 1'b1;
    send_byte(b, a);
    check(a, tag, {7'd0, a}, 8'h01);
    if (a) exp_port = b;
    wr_win = 1'b0;
    check(port_out === b, tag, port_out, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] rb;
    int s0;
    rst_n = 1'b0; abort_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    addr_sel = 4'h5; ext_hi = 8'hFF; chg_val = 8'h00; chg_load = 1'b0;
    tick(5);
    // R1 reset state
    check(port_out === 8'hFF, "R1 port", port_out, 8'hFF);
    check(sda_oe === 1'b0, "R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    check(sample_stb === 1'b0 && clear_stb === 1'b0, "R1 strobes",
          {6'd0, sample_stb, clear_stb}, 8'h00);
    rst_n = 1'b1; tick(2); started = 1'b1;
    chg_load = 1'b1; tick(1); chg_load = 1'b0;

    // R2 R3 single-byte write at 0x65
    bus_start(); quiet = 1'b0;
    send_byte(8'hCA, a); check(a, "R2 addr ack", {7'd0, a}, 8'h01);
    write_data(8'h3C, "R3 write");
    bus_stop(); quiet = 1'b1; tick(4);

    // R3 multibyte write
    bus_start(); quiet = 1'b0;
    send_byte(8'hCA, a); check(a, "R2 addr ack", {7'd0, a}, 8'h01);
    write_data(8'h81, "R3 multi 1");
    write_data(8'h7E, "R3 multi 2");
    write_data(8'h00, "R3 multi 3");
    bus_stop(); quiet = 1'b1; tick(4);

    // R4 mismatched address: silent, data ignored
    bus_start();
    send_byte(8'hCC, a); check(!a, "R4 no ack", {7'd0, a}, 8'h00);
    send_byte(8'h55, a); check(!a, "R4 data ignored", {7'd0, a}, 8'h00);
    check(port_out === 8'h00, "R4 port kept", port_out, 8'h00);
    bus_stop(); tick(4);

    // R5 R6 R7 R8 four-byte read
    bus_start(); quiet = 1'b0;
    send_byte(8'hCA, a);
    write_data(8'hF0, "R3 pre-read");
    bus_stop(); tick(4);
    ext_hi = 8'hAF; chg_val = 8'hA5; chg_load = 1'b1; tick(1); chg_load = 1'b0;
    s0 = smp_cnt;
    bus_start();
    send_byte(8'hCB, a); check(a, "R2 read ack", {7'd0, a}, 8'h01);
    check(smp_cnt == s0 + 1, "R7 addr strobe", 8'(smp_cnt - s0), 8'h01);
    recv_byte(1'b1, rb); check(rb === 8'hA0, "R5 R8 pins", rb, 8'hA0);
    ext_hi = 8'hFF;
    recv_byte(1'b1, rb); check(rb === 8'hA5, "R6 flags", rb, 8'hA5);
    check(smp_cnt == s0 + 2, "R7 resample", 8'(smp_cnt - s0), 8'h02);
    recv_byte(1'b1, rb); check(rb === 8'hF0, "R5 resampled pins", rb, 8'hF0);
    check(smp_cnt == s0 + 2, "R7 none before flags", 8'(smp_cnt - s0), 8'h02);
    recv_byte(1'b0, rb); check(rb === 8'h00, "R6 cleared flags", rb, 8'h00);
    bus_stop(); quiet = 1'b1; tick(4);

    // R9 master NACK after the flag byte
    chg_val = 8'h3C; chg_load = 1'b1; tick(1); chg_load = 1'b0;
    s0 = smp_cnt;
    bus_start(); quiet = 1'b0;
    send_byte(8'hCB, a);
    recv_byte(1'b1, rb); check(rb === 8'hF0, "R5 pins", rb, 8'hF0);
    recv_byte(1'b0, rb); check(rb === 8'h3C, "R6 flags", rb, 8'h3C);
    quiet = 1'b1;
    recv_byte(1'b0, rb); check(rb === 8'hFF, "R9 released", rb, 8'hFF);
    check(smp_cnt == s0 + 1, "R9 no strobe", 8'(smp_cnt - s0), 8'h01);
    bus_stop(); tick(4);

    // R10 abort mid-write
    s0 = smp_cnt;
    bus_start(); quiet = 1'b0;
    send_byte(8'hCA, a);
    fork
      send_byte(8'h99, a);
      begin tick(60); abort_n = 1'b0; quiet = 1'b1; tick(3); abort_n = 1'b1; end
    join
    check(!a, "R10 no ack", {7'd0, a}, 8'h00);
    check(port_out === 8'hF0, "R10 port kept", port_out, 8'hF0);
    check(smp_cnt == s0 + 1, "R10 strobes", 8'(smp_cnt - s0), 8'h01);
    bus_stop(); tick(4);

    // R11 repeated START switches to read
    bus_start(); quiet = 1'b0;
    send_byte(8'hCA, a);
    bus_start();
    send_byte(8'hCB, a); check(a, "R11 restart ack", {7'd0, a}, 8'h01);
    recv_byte(1'b0, rb); check(rb === 8'hF0, "R11 read", rb, 8'hF0);
    bus_stop(); quiet = 1'b1; tick(4);

    // R2 address extremes 0x6F and 0x60
    addr_sel = 4'hF;
    bus_start(); quiet = 1'b0;
    send_byte(8'hDE, a); check(a, "R2 0x6F", {7'd0, a}, 8'h01);
    write_data(8'h5A, "R3 at 0x6F");
    bus_stop(); quiet = 1'b1; tick(4);
    addr_sel = 4'h0;
    bus_start();
    send_byte(8'hDE, a); check(!a, "R4 old addr", {7'd0, a}, 8'h00);
    bus_stop(); tick(4);
    bus_start(); quiet = 1'b0;
    send_byte(8'hC0, a); check(a, "R2 0x60", {7'd0, a}, 8'h01);
    write_data(8'hA5, "R3 at 0x60");
    bus_stop(); quiet = 1'b1; tick(8);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule